// File: doc/BRIEF.md
# UART Receiver with Receive-Side RTS Throttling

This block turns an oversampled asynchronous serial line into characters. It checks each character against the programmed frame format and stores it, together with its framing, parity and break flags, in a four-entry receive queue. Data bits arrive least significant bit first. The frame format sets the character length to 5 to 8 bits, and an optional ninth bit is either a parity bit or, in multidrop mode, an address/data marker. Software or a DMA engine reads the head of the queue and removes it with a one-cycle `pop` pulse.

The `tick` input is a 16x bit-rate enable supplied by an external baud generator. The receiver can throttle the far-end transmitter through an active-high `rts` output. This output is dropped only when a new start bit is confirmed while the queue is already full. It comes back as soon as a slot frees up. One request output serves as both interrupt and DMA request. A select bit sources it from either "data available" or "queue full".

Status can be reported in two ways. In per-character mode the flags belong to the character at the queue head. In accumulated mode the flags are the OR of every character that has reached the head since the last `clr_err` command.

Top module: `uart_rx_rts`

## Requirements
- R1: A falling edge on the line is accepted as a start bit only if the line is still low 8 ticks later. `len` codes 0,1,2,3 select 5,6,7,8 data bits, received LSB first. The character appears right-justified on `rdata` with the unused upper bits at 0. `rx_ready` is 1 whenever the queue holds a character.
- R2: The ninth bit is present for every `pmode` except 2'b10. `pmode`=2'b00 checks parity, with `ptype`=0 for even and `ptype`=1 for odd. `pmode`=2'b01 expects the bit to equal `ptype`. A mismatch sets `st_parity` for that character. With `pmode`=2'b10 no bit is received and `st_parity` is 0.
- R3: With `pmode`=2'b11 the ninth bit is not checked. In per-character mode its received value (1 = address, 0 = data) is reported on `st_parity`.
- R4: A stop bit sampled low sets `st_frame` for that character.
- R5: `st_break` is set when all data bits, the ninth bit (if present) and the stop bit are all sampled low.
- R6: The queue holds 4 characters in arrival order, and `pop` removes the head. A character completed while the queue is full is discarded and sets `overrun`. `overrun` stays set until `clr_err`.
- R7: With `blk_err`=0, `st_frame`, `st_parity` and `st_break` show the flags of the current head character, or 0 when the queue is empty.
- R8: With `blk_err`=1, the three flags show the OR of the flags of every character that became head since the last `clr_err`.
- R9: With `rts_en`=1, `rts` falls when a start bit is confirmed while the queue is full. A full queue alone does not drop it.
- R10: A dropped `rts` returns to 1 in the first cycle in which the queue is no longer full.
- R11: With `rts_en`=0, `rts` stays 1 whatever the queue does.
- R12: `req` equals `rx_ready` when `irq_sel`=0 and equals `fifo_full` when `irq_sel`=1.
- R13: `clr_err` clears `overrun` and the accumulated flags on the next edge. It wins over an overrun arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16x bit-rate enable |
| rxd | input | 1 | Serial line, idle high |
| len | input | 2 | Data bits per character minus 5 |
| pmode | input | 2 | Ninth-bit mode: checked parity, forced, none, multidrop |
| ptype | input | 1 | Parity sense or forced level |
| rts_en | input | 1 | Receiver control of rts enabled |
| irq_sel | input | 1 | Request source: 0 data available, 1 queue full |
| blk_err | input | 1 | 0 per-character status, 1 accumulated status |
| pop | input | 1 | Remove head character |
| clr_err | input | 1 | Clear overrun and accumulated status |
| rdata | output | 8 | Head character |
| rx_ready | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds 4 characters |
| st_frame | output | 1 | Framing error status |
| st_parity | output | 1 | Parity error, or address flag in multidrop |
| st_break | output | 1 | Break status |
| overrun | output | 1 | Character lost to a full queue |
| rts | output | 1 | Request to send, active high |
| req | output | 1 | Interrupt / DMA request |

## Verification
The bench sweeps every combination of length, ninth-bit mode and parity sense. For each it sends good characters, a character with the wrong ninth bit and a character with a low stop bit. A wrong mask or bit order shows up as corrupted upper data bits. A swapped parity sense or a checked multidrop flag flips `st_parity`. Break is probed with an all-low frame and with an all-zero character that has a good stop bit, which must not flag.

A queue filled to four and then hit by a fifth start bit exposes several faults. An `rts` that drops on "full" alone, or that drops too late, is caught, as is one that reasserts late after a pop. A lost-data path that overwrites the head instead of discarding the new character is also caught. Accumulated status is checked across pops, where a per-head implementation would clear the parity flag early.

// File: rtl/uart_rx_rts.sv
module uart_rx_rts #(
  parameter int OSR   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] len,
  input  logic [1:0] pmode,
  input  logic       ptype,
  input  logic       rts_en,
  input  logic       irq_sel,
  input  logic       blk_err,
  input  logic       pop,
  input  logic       clr_err,
  output logic [7:0] rdata,
  output logic       rx_ready,
  output logic       fifo_full,
  output logic       st_frame,
  output logic       st_parity,
  output logic       st_break,
  output logic       overrun,
  output logic       rts,
  output logic       req
);
  localparam int CW   = $clog2(OSR);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [2:0]   bidx;
  logic [7:0]   sh;
  logic         parb;
  logic [1:0]   sync;
  logic         rx_prev;
  logic [10:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]  level;
  logic [2:0]   acc;
  logic         rts_drop;
  logic         pe, arr_v;
  logic [2:0]   arr_f;

  wire rxs      = sync[1];
  wire has_par  = (pmode != 2'b10);
  wire last_bit = (bidx == 3'd4 + {1'b0, len});
  wire bit_end  = tick && (cnt == CW'(OSR - 1));
  wire start_ok = tick && (st == START) && (cnt == CW'(HALF - 1)) && !rxs;
  wire push     = bit_end && (st == STOP);
  wire full     = (level == (AW+1)'(DEPTH));
  wire empty    = (level == '0);
  wire wr       = push && !full;
  wire rd       = pop && !empty;
  wire fe       = !rxs;
  wire brk      = (sh == 8'd0) && !parb && !rxs;
  wire [10:0] ent = {brk, pe, fe, sh};

  always_comb begin
    case (pmode)
      2'b00:   pe = ^sh ^ parb ^ ptype;
      2'b01:   pe = parb ^ ptype;
      2'b11:   pe = parb;
      default: pe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      rx_prev <= 1'b1;
      st      <= IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sh      <= '0;
      parb    <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      if (tick) begin
        rx_prev <= rxs;
        case (st)
          IDLE: if (rx_prev && !rxs) begin
            st  <= START;
            cnt <= '0;
          end
          START: if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
            parb <= 1'b0;
            st   <= rxs ? IDLE : DATA;
          end else cnt <= cnt + 1'b1;
          DATA: if (cnt == CW'(OSR - 1)) begin
            cnt      <= '0;
            sh[bidx] <= rxs;
            if (last_bit) st <= has_par ? PAR : STOP;
            else bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
          PAR: if (cnt == CW'(OSR - 1)) begin
            cnt  <= '0;
            parb <= rxs;
            st   <= STOP;
          end else cnt <= cnt + 1'b1;
          default: if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            st  <= IDLE;
          end else cnt <= cnt + 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) if (wr) mem[wp] <= ent;

  always_comb begin
    arr_v = 1'b0;
    arr_f = 3'b000;
    if (wr && (empty || (rd && level == (AW+1)'(1)))) begin
      arr_v = 1'b1;
      arr_f = ent[10:8];
    end else if (rd && level > (AW+1)'(1)) begin
      arr_v = 1'b1;
      arr_f = mem[rp + AW'(1)][10:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      level    <= '0;
      overrun  <= 1'b0;
      acc      <= '0;
      rts_drop <= 1'b0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (rd) rp <= rp + 1'b1;
      level <= level + (AW+1)'(wr) - (AW+1)'(rd);
      if (clr_err) overrun <= 1'b0;
      else if (push && full) overrun <= 1'b1;
      acc <= (clr_err ? 3'b000 : acc) | (arr_v ? arr_f : 3'b000);
      if (rts_en && start_ok && full) rts_drop <= 1'b1;
      else if (!full) rts_drop <= 1'b0;
    end
  end

  assign rx_ready  = !empty;
  assign fifo_full = full;
  assign rdata     = empty ? 8'd0 : mem[rp][7:0];
  assign {st_break, st_parity, st_frame} =
    blk_err ? acc : (empty ? 3'b000 : mem[rp][10:8]);
  assign rts = !(rts_en && rts_drop && full);
  assign req = irq_sel ? full : !empty;
endmodule

module uart_rx_rts_chk (
  input logic clk,
  input logic rst_n,
  input logic rts_en,
  input logic rts,
  input logic fifo_full,
  input logic rx_ready,
  input logic req,
  input logic irq_sel,
  input logic clr_err,
  input logic overrun,
  input logic blk_err,
  input logic st_parity
);
  AST_RTS_FELL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> fifo_full && rts_en); // R9
  AST_RTS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_full) |-> rts); // R10
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clr_err |=> overrun); // R6
  AST_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rx_ready); // R6
  AST_CLR_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !overrun); // R13
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    blk_err && st_parity && !clr_err |=> !blk_err || st_parity); // R8
  AST_REQ_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) && !irq_sel |-> req); // R12
endmodule

bind uart_rx_rts uart_rx_rts_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rts_en(rts_en), .rts(rts), .fifo_full(fifo_full),
  .rx_ready(rx_ready), .req(req), .irq_sel(irq_sel), .clr_err(clr_err),
  .overrun(overrun), .blk_err(blk_err), .st_parity(st_parity)
);

// File: tb/uart_rx_rts_bench.sv
module uart_rx_rts_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic rxd = 1'b1;
  logic [1:0] len = 2'd3, pmode = 2'd2;
  logic ptype = 1'b0, rts_en = 1'b0, irq_sel = 1'b0, blk_err = 1'b0;
  logic pop = 1'b0, clr_err = 1'b0;
  logic [7:0] rdata;
  logic rx_ready, fifo_full, st_frame, st_parity, st_break, overrun, rts, req;
  int n_chk = 0, n_fail = 0;
  logic rts_mid;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_rx_rts u_uart_rx_rts (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .len(len), .pmode(pmode),
    .ptype(ptype), .rts_en(rts_en), .irq_sel(irq_sel), .blk_err(blk_err),
    .pop(pop), .clr_err(clr_err), .rdata(rdata), .rx_ready(rx_ready),
    .fifo_full(fifo_full), .st_frame(st_frame), .st_parity(st_parity),
    .st_break(st_break), .overrun(overrun), .rts(rts), .req(req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v);
    rxd = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pb, input logic sb);
    @(negedge clk);
    hold(1'b0);
    rts_mid = rts;
    for (int i = 0; i < 5 + int'(len); i++) hold(d[i]);
    if (pmode != 2'b10) hold(pb);
    hold(sb);
    hold(1'b1);
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
  endtask

  function automatic logic good_pb(input logic [7:0] d, input logic adr);
    case (pmode)
      2'b00:   return ^d ^ ptype;
      2'b01:   return ptype;
      2'b11:   return adr;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] mask, d;
    logic pb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset rx_ready", rx_ready, 0);
    chk("R9 reset rts", rts, 1);
    chk("R6 reset overrun", overrun, 0);
    chk("R12 reset req", req, 0);

    for (int l = 0; l < 4; l++)
      for (int m = 0; m < 4; m++)
        for (int t = 0; t < 2; t++) begin
          len = 2'(l); pmode = 2'(m); ptype = 1'(t);
          mask = 8'hFF >> (3 - l);
          for (int k = 0; k < 3; k++) begin
            d = (8'hA5 ^ 8'(k * 59) ^ 8'(l * 16 + m * 4 + t)) & mask;
            pb = good_pb(d, 1'(k));
            send(d, pb, 1'b1);
            chk("R1 data", rdata, d);
            chk("R1 ready", rx_ready, 1);
            chk("R12 req data", req, 1);
            chk("R2 R3 parity flag", st_parity, (m == 3) ? (k & 1) : 0);
            chk("R4 frame ok", st_frame, 0);
            chk("R5 no break", st_break, 0);
            do_pop();
            chk("R6 drained", rx_ready, 0);
          end
          d = 8'h13 & mask;
          if (m < 2) begin
            send(d, ~good_pb(d, 1'b0), 1'b1);
            chk("R2 bad parity", st_parity, 1);
            do_pop();
          end
          send(d, good_pb(d, 1'b0), 1'b0);
          chk("R4 bad stop", st_frame, 1);
          chk("R5 bad stop no break", st_break, 0);
          chk("R1 data after bad stop", rdata, d);
          do_pop();
        end

    len = 2'd3; pmode = 2'd0; ptype = 1'b0;
    send(8'h00, 1'b0, 1'b0);
    chk("R5 break", st_break, 1);
    chk("R4 break frame", st_frame, 1);
    do_pop();
    send(8'h00, 1'b0, 1'b1);
    chk("R5 zero char no break", st_break, 0);
    do_pop();

    send(8'h21, 1'b0, 1'b1);
    send(8'h22, 1'b1, 1'b1);
    chk("R7 head good", st_parity, 0);
    do_pop();
    chk("R7 head bad", st_parity, 1);
    do_pop();

    blk_err = 1'b1;
    do_clr();
    send(8'h31, 1'b1, 1'b1);
    send(8'h32, 1'b0, 1'b1);
    send(8'h33, 1'b0, 1'b1);
    chk("R8 first head", st_parity, 0);
    do_pop();
    chk("R8 bad reached head", st_parity, 1);
    do_pop();
    chk("R8 accumulated", st_parity, 1);
    do_clr();
    chk("R13 clear acc", st_parity, 0);
    do_pop();
    blk_err = 1'b0;

    pmode = 2'd2; rts_en = 1'b1; irq_sel = 1'b1;
    for (int i = 0; i < 4; i++) send(8'h40 + 8'(i), 1'b0, 1'b1);
    chk("R6 full", fifo_full, 1);
    chk("R12 req full", req, 1);
    chk("R9 full alone keeps rts", rts, 1);
    send(8'h4F, 1'b0, 1'b1);
    chk("R9 rts dropped", rts_mid, 0);
    chk("R9 rts still low", rts, 0);
    chk("R6 overrun", overrun, 1);
    chk("R6 head kept", rdata, 8'h40);
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    chk("R10 rts back", rts, 1);
    chk("R12 req not full", req, 0);
    irq_sel = 1'b0;
    #1 chk("R12 req data sel", req, 1);
    for (int i = 1; i < 4; i++) begin
      chk("R6 order", rdata, 8'h40 + 8'(i));
      do_pop();
    end
    chk("R6 fifth dropped", rx_ready, 0);
    chk("R6 overrun sticky", overrun, 1);
    do_clr();
    chk("R13 overrun cleared", overrun, 0);

    rts_en = 1'b0;
    for (int i = 0; i < 5; i++) send(8'h50 + 8'(i), 1'b0, 1'b1);
    chk("R11 rts unaffected", rts_mid, 1);
    chk("R11 rts after", rts, 1);
    for (int i = 0; i < 4; i++) do_pop();
    do_clr();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule